// File: doc/BRIEF.md
# Parallel translated cache hit detector

This block decides whether a data-cache request hits, and in which cache way, when the request carries a virtual address. It does not translate first and compare afterwards. For each way of the translation buffer it builds a candidate real address from that way's stored entry and the request's page offset. It compares the cache tag of every candidate against the stored tag of every cache way at the same time. Only then does it pick one row of results, using the way that hit in the translation buffer. The slow chain of buffer compare, address multiplexer and tag compare becomes one compare stage followed by a small multiplexer.

The block sits between the translation-buffer read, the cache tag read and the stage that sequences cache misses. That stage takes the operation code, the hit way and the line-fill address. In real mode the translation buffer is bypassed: a single row of comparators uses the untranslated low address bits. The block also turns the request flags and the hit result into an operation code.

Top module: `xlat_hit_detect`

## Requirements
- R1: For translation way j, the candidate real address is entry bits 55..12 followed by request address bits 11..0. Its cache tag is real-address bits 55..11, so it is 45 bits wide (32 lines of 64 bytes). Entry bits 63..56 are ignored.
- R2: A pair (translation way j, cache way i) matches only when cache way i is valid, its tag equals the candidate tag of way j, and translation way j is valid.
- R3: In translated mode (`virtMode`=1), the reported hit and hit way are those of the row selected by `transHitWay`. They are reported only while `transHit`=1; with `transHit`=0 there is never a hit.
- R4: In real mode (`virtMode`=0), the comparison uses request address bits 55..11 directly. Translation entries, translation valids and `transHit` have no effect on the result.
- R5: When several cache ways match the selected row, the highest-numbered one is reported. With no hit, `cacheHitWay` is 0.
- R6: Load operation codes: cacheable hit gives 1 (load hit), cacheable miss gives 2 (load miss), non-cacheable miss gives 3 (non-cacheable load).
- R7: Store operation codes: cacheable hit gives 4 (store hit); cacheable miss and non-cacheable miss give 5 (store miss).
- R8: Code 6 (fault) is produced in two cases. The first is a non-cacheable request that hits. The second is an active request in translated mode without `transHit` (no valid real address), whatever the other flags are.
- R9: When `reqValid`=0, `stallIn`=1 or `maintReq`=1, the code is 0 (no operation) and `cacheHit` is 0.
- R10: `fillAddr` is the selected real address (the row of `transHitWay` in translated mode, the low 56 request bits in real mode). Its bits 63..56 and 5..0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqAddr | input | 64 | Request effective address |
| reqValid | input | 1 | Request present |
| stallIn | input | 1 | Next stage is busy; suppresses the operation |
| maintReq | input | 1 | Request is a translation maintenance command |
| virtMode | input | 1 | 1 = translate through the buffer, 0 = real mode |
| isLoad | input | 1 | 1 = load, 0 = store |
| nonCache | input | 1 | Access is non-cacheable |
| transEntry | input | 128 | Translation entries of the indexed set, way j at bits [64j+63:64j] |
| transValid | input | 2 | Valid bit per translation way |
| transHit | input | 1 | Translation buffer hit |
| transHitWay | input | 1 | Translation way that hit |
| cacheTags | input | 180 | Cache tags of the indexed set, way i at bits [45i+44:45i] |
| cacheValid | input | 4 | Valid bit per cache way |
| cacheHit | output | 1 | Cache hit |
| cacheHitWay | output | 2 | Cache way that hit |
| opCode | output | 3 | Operation code (0 none, 1 load hit, 2 load miss, 3 non-cacheable load, 4 store hit, 5 store miss, 6 fault) |
| fillAddr | output | 64 | Line-aligned real address for miss handling |

## Verification
The bench plants the candidate tag of one translation way in one cache way and then varies which translation way is reported as hitting. A design that selects the wrong row, or that ignores the translation valid bit, then reports a hit that belongs to another page. It clears the valid bit of the planted cache way to catch a design that compares tags without checking validity. It plants duplicate tags to pin the way priority. It sweeps every combination of request flags to catch a code table that confuses non-cacheable hits with misses or lets a stalled or maintenance request through. Junk in the upper entry and address bits exposes a design that leaks those bits into the tag or the fill address.

// File: rtl/xhd_pkg.sv
package xhd_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_LD_HIT  = 3'd1,
    OP_LD_MISS = 3'd2,
    OP_LD_NC   = 3'd3,
    OP_ST_HIT  = 3'd4,
    OP_ST_MISS = 3'd5,
    OP_FAULT   = 3'd6
  } opCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic go;        // request may act this cycle
    logic virt;      // translated mode
    logic useTrans;  // translated mode with a translation hit
  } ctlStrobe_t;

endpackage

// File: rtl/xhd_datapath.sv
module xhd_datapath
  import xhd_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ENTRY_W    = 64,
  parameter int REAL_W     = 56,
  parameter int PAGE_BITS  = 12,
  parameter int LINE_BITS  = 6,
  parameter int INDEX_BITS = 5,
  parameter int TRANS_WAYS = 2,
  parameter int CACHE_WAYS = 4,
  localparam int TAG_LO    = LINE_BITS + INDEX_BITS,
  localparam int TAG_W     = REAL_W - TAG_LO,
  localparam int TW_BITS   = (TRANS_WAYS > 1) ? $clog2(TRANS_WAYS) : 1,
  localparam int CW_BITS   = (CACHE_WAYS > 1) ? $clog2(CACHE_WAYS) : 1
) (
  input  ctlStrobe_t                      strobe,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [TRANS_WAYS*ENTRY_W-1:0]   transEntry,
  input  logic [TRANS_WAYS-1:0]           transValid,
  input  logic [TW_BITS-1:0]              transHitWay,
  input  logic [CACHE_WAYS*TAG_W-1:0]     cacheTags,
  input  logic [CACHE_WAYS-1:0]           cacheValid,
  output logic                            cacheHit,
  output logic [CW_BITS-1:0]              cacheHitWay,
  output logic [ADDR_W-1:0]               fillAddr
);

  // scan all cache ways for one tag; highest matching way wins
  function automatic logic [CW_BITS:0] scanWays(
    input logic [TAG_W-1:0]            tag,
    input logic [CACHE_WAYS*TAG_W-1:0] tags,
    input logic [CACHE_WAYS-1:0]       vld,
    input logic                        gate
  );
    logic [CW_BITS:0] res;
    res = '0;
    for (int i = 0; i < CACHE_WAYS; i++) begin
      if (gate && vld[i] && tags[i*TAG_W +: TAG_W] == tag)
        res = {1'b1, CW_BITS'(i)};
    end
    return res;
  endfunction

  logic [REAL_W-1:0]  candRa  [TRANS_WAYS];
  logic [CW_BITS:0]   rowRes  [TRANS_WAYS];
  logic               unusedEntry [TRANS_WAYS];
  logic [CW_BITS:0]   realRes;
  logic [CW_BITS:0]   selRes;
  logic [REAL_W-1:0]  selRa;
  logic               unusedAddr;

  // one comparator row per translation way
  for (genvar j = 0; j < TRANS_WAYS; j++) begin : g_row
    assign candRa[j] = {transEntry[j*ENTRY_W + REAL_W-1 : j*ENTRY_W + PAGE_BITS],
                        reqAddr[PAGE_BITS-1:0]};
    assign rowRes[j] = scanWays(candRa[j][REAL_W-1:TAG_LO], cacheTags, cacheValid,
                                strobe.go && transValid[j]);
    assign unusedEntry[j] = ^{transEntry[j*ENTRY_W + ENTRY_W-1 : j*ENTRY_W + REAL_W],
                              transEntry[j*ENTRY_W + PAGE_BITS-1 : j*ENTRY_W]};
  end

  // real-mode comparator row
  assign realRes    = scanWays(reqAddr[REAL_W-1:TAG_LO], cacheTags, cacheValid, strobe.go);
  assign unusedAddr = ^reqAddr[ADDR_W-1:REAL_W];

  // late selection by the translation hit way
  always_comb begin
    if (strobe.virt) begin
      selRes = strobe.useTrans ? rowRes[transHitWay] : '0;
      selRa  = candRa[transHitWay];
    end else begin
      selRes = realRes;
      selRa  = reqAddr[REAL_W-1:0];
    end
  end

  assign cacheHit    = selRes[CW_BITS];
  assign cacheHitWay = selRes[CW_BITS-1:0];
  assign fillAddr    = {{(ADDR_W-REAL_W){1'b0}}, selRa[REAL_W-1:LINE_BITS],
                        {LINE_BITS{1'b0}}};

endmodule

// File: rtl/xhd_control.sv
module xhd_control
  import xhd_pkg::*;
(
  input  logic       reqValid,
  input  logic       stallIn,
  input  logic       maintReq,
  input  logic       virtMode,
  input  logic       isLoad,
  input  logic       nonCache,
  input  logic       transHit,
  input  logic       cacheHit,
  output ctlStrobe_t strobe,
  output opCode_e    opCode
);

  logic raOk;

  always_comb begin
    strobe.go       = reqValid && !stallIn && !maintReq;
    strobe.virt     = virtMode;
    strobe.useTrans = virtMode && transHit;
    raOk            = transHit || !virtMode;
  end

  always_comb begin
    opCode = OP_IDLE;
    if (strobe.go) begin
      if (!raOk || (nonCache && cacheHit))
        opCode = OP_FAULT;
      else if (isLoad)
        opCode = nonCache ? OP_LD_NC : (cacheHit ? OP_LD_HIT : OP_LD_MISS);
      else
        opCode = cacheHit ? OP_ST_HIT : OP_ST_MISS;
    end
  end

  always_comb begin
    // R9
    if (!reqValid || stallIn || maintReq)
      idle_no_hit_chk: assert (!cacheHit && opCode == OP_IDLE);
    // R3
    if (virtMode && !transHit)
      untranslated_no_hit_chk: assert (!cacheHit);
    // R8
    if (cacheHit && nonCache)
      nc_hit_fault_chk: assert (opCode == OP_FAULT);
    // R6
    if (cacheHit && isLoad && !nonCache)
      load_hit_code_chk: assert (opCode == OP_LD_HIT);
  end

endmodule

// File: rtl/xlat_hit_detect.sv
module xlat_hit_detect
  import xhd_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ENTRY_W    = 64,
  parameter int REAL_W     = 56,
  parameter int PAGE_BITS  = 12,
  parameter int LINE_BITS  = 6,
  parameter int INDEX_BITS = 5,
  parameter int TRANS_WAYS = 2,
  parameter int CACHE_WAYS = 4,
  localparam int TAG_W     = REAL_W - LINE_BITS - INDEX_BITS,
  localparam int TW_BITS   = (TRANS_WAYS > 1) ? $clog2(TRANS_WAYS) : 1,
  localparam int CW_BITS   = (CACHE_WAYS > 1) ? $clog2(CACHE_WAYS) : 1
) (
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqValid,
  input  logic                          stallIn,
  input  logic                          maintReq,
  input  logic                          virtMode,
  input  logic                          isLoad,
  input  logic                          nonCache,
  input  logic [TRANS_WAYS*ENTRY_W-1:0] transEntry,
  input  logic [TRANS_WAYS-1:0]         transValid,
  input  logic                          transHit,
  input  logic [TW_BITS-1:0]            transHitWay,
  input  logic [CACHE_WAYS*TAG_W-1:0]   cacheTags,
  input  logic [CACHE_WAYS-1:0]         cacheValid,
  output logic                          cacheHit,
  output logic [CW_BITS-1:0]            cacheHitWay,
  output logic [2:0]                    opCode,
  output logic [ADDR_W-1:0]             fillAddr
);

  ctlStrobe_t strobe;
  opCode_e    opEnum;

  xhd_control u_ctl (
    .reqValid (reqValid),
    .stallIn  (stallIn),
    .maintReq (maintReq),
    .virtMode (virtMode),
    .isLoad   (isLoad),
    .nonCache (nonCache),
    .transHit (transHit),
    .cacheHit (cacheHit),
    .strobe   (strobe),
    .opCode   (opEnum)
  );

  xhd_datapath #(
    .ADDR_W     (ADDR_W),
    .ENTRY_W    (ENTRY_W),
    .REAL_W     (REAL_W),
    .PAGE_BITS  (PAGE_BITS),
    .LINE_BITS  (LINE_BITS),
    .INDEX_BITS (INDEX_BITS),
    .TRANS_WAYS (TRANS_WAYS),
    .CACHE_WAYS (CACHE_WAYS)
  ) u_dp (
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .transEntry  (transEntry),
    .transValid  (transValid),
    .transHitWay (transHitWay),
    .cacheTags   (cacheTags),
    .cacheValid  (cacheValid),
    .cacheHit    (cacheHit),
    .cacheHitWay (cacheHitWay),
    .fillAddr    (fillAddr)
  );

  assign opCode = opEnum;

endmodule

// File: tb/sim_xlat_hit_detect.sv
module sim_xlat_hit_detect;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0]  reqAddr = '0;
  logic         reqValid = 0, stallIn = 0, maintReq = 0, virtMode = 0;
  logic         isLoad = 0, nonCache = 0, transHit = 0;
  logic [127:0] transEntry = '0;
  logic [1:0]   transValid = '0;
  logic         transHitWay = 0;
  logic [179:0] cacheTags = '0;
  logic [3:0]   cacheValid = '0;
  logic         cacheHit;
  logic [1:0]   cacheHitWay;
  logic [2:0]   opCode;
  logic [63:0]  fillAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  xlat_hit_detect u0 (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [2:0] expOp(input logic go, input logic raOk, input logic ld,
                                       input logic nc, input logic hit);
    if (!go) return 3'd0;
    if (!raOk) return 3'd6;
    if (nc && hit) return 3'd6;
    if (ld) return nc ? 3'd3 : (hit ? 3'd1 : 3'd2);
    return hit ? 3'd4 : 3'd5;
  endfunction

  // distinct filler tags that never equal a planted tag
  task automatic fillerTags();
    for (int i = 0; i < 4; i++) cacheTags[i*45 +: 45] = 45'h1555_0000_0000 + 45'(i);
  endtask

  localparam logic [63:0] ENT0 = 64'hFF12_3456_789A_BCDE;
  localparam logic [63:0] ENT1 = 64'hEE65_4321_0FED_C123;

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state: all inputs idle
    repeat (2) @(negedge clk);
    #1;
    check("R9 reset op", 64'(opCode), 64'd0);
    check("R9 reset hit", 64'(cacheHit), 64'd0);
    check("R10 reset fill", fillAddr, 64'd0);

    // sweep 1: real mode, every flag combination, planted way, valid or not
    transEntry = {ENT1, ENT0};
    transValid = 2'b00; transHit = 0;
    for (int ctl = 0; ctl < 32; ctl++) begin
      for (int pw = 0; pw < 5; pw++) begin
        for (int vv = 0; vv < 2; vv++) begin
          logic go, hit, ld, nc;
          logic [63:0] a;
          @(negedge clk);
          a = 64'hAB00_0000_0000_0000 | (64'(ctl) * 64'h0000_1357_9BDF_1000) | 64'h0000_0000_0000_07C5;
          reqAddr = a;
          reqValid = ctl[0]; stallIn = ctl[1]; maintReq = ctl[2];
          ld = ctl[3]; nc = ctl[4];
          isLoad = ld; nonCache = nc; virtMode = 0;
          fillerTags();
          cacheValid = 4'hF;
          if (pw < 4) begin
            cacheTags[pw*45 +: 45] = 45'(a >> 11);
            if (vv == 0) cacheValid[pw] = 1'b0;
          end
          go = ctl[0] && !ctl[1] && !ctl[2];
          hit = go && pw < 4 && vv == 1;
          #1;
          check("R4 real hit", 64'(cacheHit), 64'(hit));
          check("R5 real way", 64'(cacheHitWay), hit ? 64'(pw) : 64'd0);
          if (!go) check("R9 idle op", 64'(opCode), 64'd0);
          else if (ld) check("R6 load op", 64'(opCode), 64'(expOp(go, 1'b1, ld, nc, hit)));
          else check("R7 store op", 64'(opCode), 64'(expOp(go, 1'b1, ld, nc, hit)));
          if (nc && hit) check("R8 nc hit fault", 64'(opCode), 64'd6);
          check("R10 real fill", fillAddr, a & 64'h00FF_FFFF_FFFF_FFC0);
        end
      end
    end

    // sweep 2: translated mode, row selection and validity
    for (int hw = 0; hw < 2; hw++) begin
      for (int th = 0; th < 2; th++) begin
        for (int tv = 0; tv < 4; tv++) begin
          for (int cw = 0; cw < 5; cw++) begin
            for (int src = 0; src < 2; src++) begin
              logic hit;
              logic [63:0] a, e;
              @(negedge clk);
              a = 64'h7700_0000_0000_0000 | 64'(src * 16'h0800) | 64'h0000_0000_0000_03A7;
              reqAddr = a;
              reqValid = 1; stallIn = 0; maintReq = 0; virtMode = 1;
              isLoad = 1; nonCache = 0;
              transEntry = {ENT1, ENT0};
              transValid = 2'(tv); transHit = th[0]; transHitWay = hw[0];
              fillerTags();
              cacheValid = 4'hF;
              e = (src == 0) ? ENT0 : ENT1;
              if (cw < 4)
                cacheTags[cw*45 +: 45] = 45'(((e & 64'h00FF_FFFF_FFFF_F000) | (a & 64'hFFF)) >> 11);
              hit = (th == 1) && tv[hw] && (cw < 4) && (src == hw);
              #1;
              check("R3 virt hit", 64'(cacheHit), 64'(hit));
              check("R2 virt way", 64'(cacheHitWay), hit ? 64'(cw) : 64'd0);
              check("R8 virt op", 64'(opCode), 64'(expOp(1'b1, th[0], 1'b1, 1'b0, hit)));
              e = (hw == 0) ? ENT0 : ENT1;
              check("R1 virt fill", fillAddr,
                    (e & 64'h00FF_FFFF_FFFF_F000) | (a & 64'h0000_0000_0000_0FC0));
            end
          end
        end
      end
    end

    // sweep 3: duplicate matches in real mode, highest way wins
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = lo + 1; hi < 4; hi++) begin
        logic [63:0] a;
        @(negedge clk);
        a = 64'h0012_3456_789A_B800 + 64'(lo * 64 + hi);
        reqAddr = a; reqValid = 1; stallIn = 0; maintReq = 0; virtMode = 0;
        isLoad = 0; nonCache = 0; transHit = 0;
        fillerTags(); cacheValid = 4'hF;
        cacheTags[lo*45 +: 45] = 45'(a >> 11);
        cacheTags[hi*45 +: 45] = 45'(a >> 11);
        #1;
        check("R5 priority way", 64'(cacheHitWay), 64'(hi));
        check("R7 store hit op", 64'(opCode), 64'd4);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule